// File: doc/BRIEF.md
# Audio Serial Output Port

This block turns parallel stereo audio words into a three-wire serial stream: a data line, a bit clock and a frame sync. A producer hands over one 24-bit sample at a time with a strobe and a left/right flag. The block keeps each sample in a per-channel holding register. At the start of every stereo frame it takes the held pair, then shifts each word out MSB first inside a 32-period slot. The 8 bit positions after the sample are filled with zeros.

Two run-time controls set how the port behaves. The first chooses the clocking role. As master, the block divides its system clock to make the bit clock and frame sync and drives both pins. As slave, it releases both pins and follows an external bit clock and frame sync, which it samples through two-flop synchronizers. The second control picks the launch edge, which is the bit-clock edge on which data and frame sync change. The far side captures on the opposite edge. The pins are modelled as an output value plus an output enable. An enable at 0 means the pin is high impedance.

Top module: `audio_serial_out`

## Requirements
- R1: In master mode (`cfgMaster`=1) the bit clock toggles every `HALF_DIV` system clocks, so its period is 2*`HALF_DIV` clocks. `bclkOe` and `lrckOe` follow `cfgMaster` with one clock of delay.
- R2: Every slot holds exactly 32 launch edges. The frame sync is 1 during the left slot and 0 during the right slot, so a frame spans 64 bit-clock periods.
- R3: When `cfgFallLaunch`=1, data and frame sync change only on the falling bit-clock edge. When it is 0, they change only on the rising edge. The receiver captures on the other edge.
- R4: Each slot starts with the sample MSB (bit 23) on the same launch edge where the frame sync changes. The other sample bits follow in descending order, and the last 8 of the 32 bits are 0.
- R5: A strobe (`sampleValid`=1) with `sampleLeft`=1 stores `sampleData` as the left sample, and with `sampleLeft`=0 as the right sample. Both held values are taken at the start of the next left slot. The right value taken there is the one sent in that frame's right slot. If no new sample arrives, the previous pair is sent again.
- R6: In slave mode both enables are 0 and `bclkOut`/`lrckOut` are 0. Launch edges are detected on `bclkIn` after a two-flop synchronizer. A change of `lrckIn` seen at a launch edge starts a slot: a new level of 1 starts a left slot and 0 starts a right slot. The serial data changes 3 system clocks after the launch edge at the pin.
- R7: While `rstN` is low, `bclkOe`, `lrckOe`, `bclkOut`, `lrckOut` and `sdata` are all 0. The clock and sync pins are therefore high impedance.
- R8: Switching to master at run time, without a reset, restarts framing. The first launch edge after the switch begins a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMaster | input | 1 | 1 = master, 0 = slave |
| cfgFallLaunch | input | 1 | 1 = launch on falling edge, 0 = launch on rising edge |
| sampleValid | input | 1 | Sample strobe |
| sampleLeft | input | 1 | 1 = strobed sample is left, 0 = right |
| sampleData | input | SAMPLE_W | Audio sample, two's complement |
| bclkIn | input | 1 | External bit clock (slave) |
| lrckIn | input | 1 | External frame sync (slave) |
| bclkOut | output | 1 | Generated bit clock (master) |
| bclkOe | output | 1 | Bit-clock pin drive enable |
| lrckOut | output | 1 | Generated frame sync (master) |
| lrckOe | output | 1 | Frame-sync pin drive enable |
| sdata | output | 1 | Serial audio data |

## Verification
The assertions check the following on every cycle. In master mode a frame-sync change always falls on a bit-clock move to the launch level. At most one load or shift strobe is active at a time. The 8 trailing positions of a slot are zero. Held samples stay unchanged without a strobe. A settled slave mode keeps both pins released and low. Some behaviour only the bench scenarios can show. That covers the 32-edge slot length, the bit-clock period, words recovered at the capture edge under both edge settings and in both roles, the frame-boundary latching of samples written mid-frame, the run-time return to master, and the pin state during reset.

// File: rtl/audio_serial_pkg.sv
package audio_serial_pkg;

  // One-cycle commands from the control to the datapath
  typedef struct packed {
    logic loadLeft;   // frame start: take held pair, present left MSB
    logic loadRight;  // right slot start: present right MSB
    logic shift;      // advance one bit inside the current slot
  } aso_strobe_t;

endpackage

// File: rtl/aso_ctrl.sv
module aso_ctrl
  import audio_serial_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int SLOT_W   = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgMaster,
  input  logic        cfgFallLaunch,
  input  logic        bclkIn,
  input  logic        lrckIn,
  output aso_strobe_t strobe,
  output logic        bclkOut,
  output logic        lrckOut,
  output logic        pinOe
);

  localparam int FRAME_W = 2 * SLOT_W;
  localparam int POS_W   = $clog2(FRAME_W);
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_W - 1);
  localparam logic [POS_W-1:0] POS_RIGHT = POS_W'(SLOT_W);

  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] pos, nextPos;
  logic bclkReg, lrckReg, started, prevMaster;
  logic bSync1, bSync2, bPrev, lSync1, lSync2, lLast;
  logic tick, launchM, launchS, modeChg, slotStartS;

  always_comb begin
    tick       = (divCnt == DIV_LAST);
    launchM    = cfgMaster && tick && (bclkReg == cfgFallLaunch);
    modeChg    = (cfgMaster != prevMaster);
    launchS    = !cfgMaster && (bSync2 != bPrev) && (bPrev == cfgFallLaunch);
    slotStartS = launchS && (lSync2 != lLast);
    nextPos    = (pos == POS_LAST) ? '0 : pos + 1'b1;
  end

  always_comb begin
    strobe = '0;
    if (cfgMaster) begin
      if (launchM && !modeChg) begin
        if (!started)                 strobe.loadLeft  = 1'b1;
        else if (nextPos == '0)       strobe.loadLeft  = 1'b1;
        else if (nextPos == POS_RIGHT) strobe.loadRight = 1'b1;
        else                          strobe.shift     = 1'b1;
      end
    end else if (launchS) begin
      if (slotStartS) begin
        strobe.loadLeft  = lSync2;
        strobe.loadRight = !lSync2;
      end else begin
        strobe.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      pos        <= '0;
      bclkReg    <= 1'b0;
      lrckReg    <= 1'b0;
      started    <= 1'b0;
      prevMaster <= 1'b0;
      pinOe      <= 1'b0;
      bSync1     <= 1'b0;
      bSync2     <= 1'b0;
      bPrev      <= 1'b0;
      lSync1     <= 1'b0;
      lSync2     <= 1'b0;
      lLast      <= 1'b0;
    end else begin
      prevMaster <= cfgMaster;
      pinOe      <= cfgMaster;
      bSync1     <= bclkIn;
      bSync2     <= bSync1;
      bPrev      <= bSync2;
      lSync1     <= lrckIn;
      lSync2     <= lSync1;
      if (launchS) lLast <= lSync2;
      if (!cfgMaster) begin
        divCnt  <= '0;
        bclkReg <= 1'b0;
        lrckReg <= 1'b0;
        started <= 1'b0;
        pos     <= '0;
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) bclkReg <= ~bclkReg;
        if (modeChg) begin
          started <= 1'b0;
          pos     <= '0;
        end else if (launchM) begin
          if (!started) begin
            started <= 1'b1;
            pos     <= '0;
            lrckReg <= 1'b1;
          end else begin
            pos     <= nextPos;
            lrckReg <= (nextPos < POS_RIGHT);
          end
        end
      end
    end
  end

  assign bclkOut = bclkReg;
  assign lrckOut = lrckReg;

  // R3: a frame-sync change in steady master mode lands on a move to the launch level
  a_r3_sync_on_launch: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && $past(cfgMaster) && $stable(cfgFallLaunch) && (lrckReg != $past(lrckReg)))
      |-> ((bclkReg != $past(bclkReg)) && (bclkReg == !cfgFallLaunch)));

  // R6: settled slave mode keeps both pins released and low
  a_r6_slave_released: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMaster && !$past(cfgMaster)) |-> (!pinOe && !bclkReg && !lrckReg));

endmodule

// File: rtl/aso_data.sv
module aso_data
  import audio_serial_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic                sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  aso_strobe_t         strobe,
  output logic                sdata
);

  localparam int PAD_W = SLOT_W - SAMPLE_W;
  localparam int CNT_W = $clog2(SLOT_W + 1);

  logic [SAMPLE_W-1:0] holdL, holdR, activeR;
  logic [SLOT_W-1:0]   shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdL <= '0;
      holdR <= '0;
    end else if (sampleValid) begin
      if (sampleLeft) holdL <= sampleData;
      else            holdR <= sampleData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeR  <= '0;
      shiftReg <= '0;
    end else if (strobe.loadLeft) begin
      activeR  <= holdR;
      shiftReg <= {holdL, {PAD_W{1'b0}}};
    end else if (strobe.loadRight) begin
      shiftReg <= {activeR, {PAD_W{1'b0}}};
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[SLOT_W-2:0], 1'b0};
    end
  end

  assign sdata = shiftReg[SLOT_W-1];

  // Checker support: shifts since the last slot load
  logic [CNT_W-1:0] chkShifts;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkShifts <= '0;
    else if (strobe.loadLeft || strobe.loadRight) chkShifts <= '0;
    else if (strobe.shift && (chkShifts != CNT_W'(SLOT_W))) chkShifts <= chkShifts + 1'b1;
  end

  // R2: at most one datapath command per cycle
  a_r2_one_command: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLeft, strobe.loadRight, strobe.shift}));

  // R4: the trailing positions of a slot are zero
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((chkShifts >= CNT_W'(SAMPLE_W)) && (chkShifts < CNT_W'(SLOT_W))) |-> !sdata);

  // R5: held samples change only on a strobe
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(holdL) && $stable(holdR)));

endmodule

// File: rtl/audio_serial_out.sv
module audio_serial_out
  import audio_serial_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMaster,
  input  logic                cfgFallLaunch,
  input  logic                sampleValid,
  input  logic                sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                bclkIn,
  input  logic                lrckIn,
  output logic                bclkOut,
  output logic                bclkOe,
  output logic                lrckOut,
  output logic                lrckOe,
  output logic                sdata
);

  aso_strobe_t strobe;
  logic pinOe;

  aso_ctrl #(.HALF_DIV(HALF_DIV), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgFallLaunch(cfgFallLaunch),
    .bclkIn(bclkIn), .lrckIn(lrckIn), .strobe(strobe),
    .bclkOut(bclkOut), .lrckOut(lrckOut), .pinOe(pinOe)
  );

  aso_data #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_data (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleLeft(sampleLeft),
    .sampleData(sampleData), .strobe(strobe), .sdata(sdata)
  );

  assign bclkOe = pinOe;
  assign lrckOe = pinOe;

endmodule

// File: tb/audio_serial_out_bench.sv
module audio_serial_out_bench;

  localparam int SW = 24;
  localparam int HD = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMaster = 1'b0, cfgFallLaunch = 1'b1;
  logic sampleValid = 1'b0, sampleLeft = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic bclkIn = 1'b0, lrckIn = 1'b0;
  logic bclkOut, bclkOe, lrckOut, lrckOe, sdata;

  int tests = 0, fails = 0, cyc = 0;

  audio_serial_out #(.SAMPLE_W(SW), .SLOT_W(32), .HALF_DIV(HD)) u_audio_serial_out (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgFallLaunch(cfgFallLaunch),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft), .sampleData(sampleData),
    .bclkIn(bclkIn), .lrckIn(lrckIn), .bclkOut(bclkOut), .bclkOe(bclkOe),
    .lrckOut(lrckOut), .lrckOe(lrckOe), .sdata(sdata)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL R1 watchdog: actual %0d expected below %0d", cyc, 150000);
      finishRun();
    end
  end

  // ---------------- behavioural reference model ----------------
  int mDiv, mPos, curIdx, ev, np;
  bit mB, mL, mStarted, mPrevM, mOe, s1, s2, sp, l1, l2, lLast, tck, lm, chg, ls;
  logic [SW-1:0] holdL, holdR, actR, curWord;
  bit eSd;

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mPos = 0; mB = 0; mL = 0; mStarted = 0; mPrevM = 0; mOe = 0;
      s1 = 0; s2 = 0; sp = 0; l1 = 0; l2 = 0; lLast = 0;
      holdL = '0; holdR = '0; actR = '0; curWord = '0; curIdx = 32;
    end else begin
      tck = (mDiv == HD - 1);
      lm  = cfgMaster && tck && (mB == cfgFallLaunch);
      chg = (cfgMaster != mPrevM);
      ls  = !cfgMaster && (s2 != sp) && (sp == cfgFallLaunch);
      ev = 0;
      if (cfgMaster) begin
        if (lm && !chg) begin
          if (!mStarted) ev = 1;
          else begin
            np = (mPos + 1) % 64;
            ev = (np == 0) ? 1 : (np == 32) ? 2 : 3;
          end
        end
      end else if (ls) begin
        ev = (l2 != lLast) ? (l2 ? 1 : 2) : 3;
      end
      case (ev)
        1: begin curWord = holdL; actR = holdR; curIdx = 0; end
        2: begin curWord = actR; curIdx = 0; end
        3: if (curIdx < 32) curIdx++;
        default: ;
      endcase
      if (sampleValid) begin
        if (sampleLeft) holdL = sampleData; else holdR = sampleData;
      end
      mPrevM = cfgMaster; mOe = cfgMaster;
      if (ls) lLast = l2;
      sp = s2; s2 = s1; s1 = bclkIn;
      l2 = l1; l1 = lrckIn;
      if (!cfgMaster) begin
        mDiv = 0; mB = 0; mL = 0; mStarted = 0; mPos = 0;
      end else begin
        mDiv = tck ? 0 : mDiv + 1;
        if (tck) mB = !mB;
        if (chg) begin mStarted = 0; mPos = 0; end
        else if (lm) begin
          if (!mStarted) begin mStarted = 1; mPos = 0; mL = 1; end
          else begin mPos = (mPos + 1) % 64; mL = (mPos < 32); end
        end
      end
    end
    eSd = (curIdx < SW) ? curWord[SW-1-curIdx] : 1'b0;
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(bclkOut == mB, "R1", "model bclkOut", bclkOut, mB);
      check(bclkOe == mOe && lrckOe == mOe, "R6", "model pin enables", {bclkOe, lrckOe}, {mOe, mOe});
      check(lrckOut == mL, "R2", "model lrckOut", lrckOut, mL);
      check(sdata == eSd, "R4", "model sdata", sdata, eSd);
    end
  end

  // ---------------- master-mode receiver monitor ----------------
  bit monEn = 0;
  bit pB, pL, pS;
  int capCnt, slotsSeen, lastRise, wordsOk;
  logic [31:0] capWord;
  logic [SW-1:0] pendL = '0, pendR = '0, frameL, frameR;

  always @(negedge clk) begin
    if (!monEn) begin
      capCnt = 0; slotsSeen = 0; lastRise = -1;
    end else begin
      if (bclkOut && !pB) begin
        if (lastRise >= 0) check(cyc - lastRise == 2 * HD, "R1", "bit clock period", cyc - lastRise, 2 * HD);
        lastRise = cyc;
      end
      if (sdata != pS || lrckOut != pL)
        check(bclkOut != pB && bclkOut == !cfgFallLaunch, "R3", "change off launch edge", bclkOut, !cfgFallLaunch);
      if (lrckOut != pL) begin
        if (slotsSeen > 0) begin
          check(capCnt == 32, "R2", "capture edges per slot", capCnt, 32);
          if (pL) check(capWord == {frameL, 8'h00}, "R4", "left word", capWord, {frameL, 8'h00});
          else    check(capWord == {frameR, 8'h00}, "R5", "right word", capWord, {frameR, 8'h00});
          wordsOk++;
        end
        if (lrckOut) begin frameL = pendL; frameR = pendR; end
        slotsSeen++;
        capCnt = 0;
      end
      if (bclkOut != pB && bclkOut == cfgFallLaunch) begin
        capWord = {capWord[30:0], sdata};
        capCnt++;
      end
    end
    pB = bclkOut; pL = lrckOut; pS = sdata;
  end

  // ---------------- stimulus ----------------
  task automatic writePair(input logic [SW-1:0] l, input logic [SW-1:0] r);
    sampleValid = 1; sampleLeft = 1; sampleData = l;
    @(negedge clk);
    sampleLeft = 0; sampleData = r;
    @(negedge clk);
    sampleValid = 0; sampleData = '0;
    pendL = l; pendR = r;
  endtask

  task automatic doReset(input bit fall, input bit bIdle);
    @(negedge clk);
    rstN = 0; cfgMaster = 1; cfgFallLaunch = fall; bclkIn = bIdle; lrckIn = 0;
    repeat (3) begin
      @(negedge clk);
      check(!bclkOe && !lrckOe && !bclkOut && !lrckOut && !sdata, "R7", "pins during reset",
            {bclkOe, lrckOe, bclkOut, lrckOut, sdata}, 0);
    end
    cfgMaster = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic runMaster(input int frames, input bit midWrite,
                           input logic [SW-1:0] nl, input logic [SW-1:0] nr);
    wordsOk = 0;
    monEn = 1; cfgMaster = 1;
    @(negedge clk);
    check(bclkOe && lrckOe, "R1", "enables after master select", {bclkOe, lrckOe}, 3);
    repeat (frames) begin
      @(posedge lrckOut);
      @(negedge clk);
      if (midWrite) begin repeat (20) @(negedge clk); writePair(nl, nr); midWrite = 0; end
    end
    @(posedge lrckOut);
    repeat (4) @(negedge clk);
    check(wordsOk >= 2 * frames - 1, "R2", "words recovered", wordsOk, 2 * frames - 1);
    monEn = 0;
  endtask

  task automatic runSlave(input int frames, input bit fall);
    logic [31:0] w;
    for (int f = 0; f < frames; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        w = '0;
        for (int b = 0; b < 32; b++) begin
          bclkIn = !fall;
          if (b == 0) lrckIn = (ch == 0);
          repeat (4) @(negedge clk);
          bclkIn = fall;
          w = {w[30:0], sdata};
          repeat (4) @(negedge clk);
        end
        if (ch == 0) check(w == {pendL, 8'h00}, "R6", "slave left word", w, {pendL, 8'h00});
        else         check(w == {pendR, 8'h00}, "R6", "slave right word", w, {pendR, 8'h00});
      end
    end
  endtask

  initial begin
    // Master, falling-edge launch; pair changes mid-frame
    doReset(1'b1, 1'b0);
    writePair(24'hA5C3F1, 24'h3C5A0F);
    runMaster(3, 1'b1, 24'h800001, 24'h7FFFFE);

    // Master, rising-edge launch
    doReset(1'b0, 1'b0);
    writePair(24'hFFFFFF, 24'h000001);
    runMaster(2, 1'b0, '0, '0);

    // Slave, falling-edge launch
    doReset(1'b1, 1'b1);
    writePair(24'h123456, 24'hFEDCBA);
    repeat (4) @(negedge clk);
    check(!bclkOe && !lrckOe, "R6", "slave enables", {bclkOe, lrckOe}, 0);
    runSlave(2, 1'b1);

    // Slave, rising-edge launch, then switch to master without reset
    doReset(1'b0, 1'b0);
    writePair(24'h5A5A5A, 24'hC0FFEE);
    runSlave(2, 1'b0);
    writePair(24'h0F0F0F, 24'hF0F0F0);
    repeat (10) @(negedge clk);
    begin : r8_switch
      monEn = 1; cfgMaster = 1;
      @(posedge lrckOut);
      @(negedge clk);
      check(lrckOut == 1'b1, "R8", "first slot after switch is left", lrckOut, 1);
      check(sdata == 1'b0, "R8", "left MSB of 0F0F0F", sdata, 0);
      monEn = 0;
    end
    runMaster(2, 1'b0, '0, '0);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule